// File: doc/BRIEF.md
# DSP Integer Increment/Decrement Unit

This block is the integer step unit of a fixed-point DSP datapath. It takes a 40-bit register operand and adds one to it or subtracts one from it. The operand is 8 guard bits above a 32-bit word. Only a 24-bit slice takes part in the arithmetic: the guard bits joined with the upper half of the word. The lower half of the source is not used, and the lower half of the destination is always written as zero.

Either side may be a register without guard bits. A source without guard bits gets its word sign bit copied into the guard positions. A destination without guard bits keeps only the upper half-word of the result. Overflow can be clamped to the largest positive or smallest negative value.

Each issued operation is registered and appears one clock later as a result with a write-enable. The five status bits (decimal carry, negative, zero, overflow, greater-than) are held in the block and change only for unconditional operations. A conditional operation writes its result when its condition is true and never changes the status bits.

Internally the unit sorts every cycle into one of four issue kinds, and each kind has fixed effects on the registered outputs:

| Kind | When | Result and write-enable | Status bits |
|---|---|---|---|
| `KIND_IDLE` | `issue` = 0 | no write | held |
| `KIND_FULL` | issue, unconditional | written | updated |
| `KIND_DATA_ONLY` | issue, conditional, condition true | written | held |
| `KIND_SQUASH` | issue, conditional, condition false | no write | held |

Top module: `dsp_incdec_alu`

## Requirements
- R1: Bits 15..0 of `result` are zero whenever `wr_en` is 1.
- R2: Bits 15..0 of `src_operand` have no effect on `result` or on any status bit.
- R3: When `src_has_guard` is 0, the guard bits 39..32 of `src_operand` are ignored. Bit 31 is copied into the 8 guard positions before the step.
- R4: When `dst_has_guard` is 0, `result[39:32]` equals eight copies of `result[31]`, and only the stepped upper half-word is kept.
- R5: `op_dec` = 0 adds one and `op_dec` = 1 subtracts one, modulo 2^24, on the 24-bit slice {guard, bits 31..16}.
- R6: With `sat_en` = 1 and V set, the result is 0x00_7FFF_0000 on an increment and 0xFF_8000_0000 on a decrement, instead of the wrapped value.
- R7: V is the signed overflow of the 24-bit slice when `dst_has_guard` is 1. It is the signed overflow of the 16-bit upper half-word when `dst_has_guard` is 0.
- R8: After an unconditional operation, N equals `result[39]`, Z is 1 exactly when all 40 result bits are zero, and GT equals (not N) and (not Z).
- R9: DC is the carry out of bit 23 of the slice on an increment, and the borrow into bit 23 on a decrement.
- R10: A conditional operation (`cond_mode` = 1) with `cond_true` = 1 writes its result (`wr_en` = 1) and leaves all five status bits unchanged.
- R11: A conditional operation with `cond_true` = 0 gives `wr_en` = 0, leaves `result` and the status bits unchanged, and has no other effect.
- R12: In a cycle with `issue` = 0, the next cycle has `wr_en` = 0, with `result` and the status bits held.
- R13: During and after reset, before the first issue, `result`, `wr_en` and all status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An operation is presented this cycle |
| op_dec | input | 1 | 0 = increment by one, 1 = decrement by one |
| src_operand | input | 40 | Source register value {guard[7:0], word[31:0]} |
| src_has_guard | input | 1 | Source register carries valid guard bits |
| dst_has_guard | input | 1 | Destination register carries guard bits |
| sat_en | input | 1 | Clamp on overflow |
| cond_mode | input | 1 | Operation is conditional |
| cond_true | input | 1 | Condition result for a conditional operation |
| result | output | 40 | Registered result value |
| wr_en | output | 1 | Result is to be written to the destination |
| st_dc | output | 1 | Decimal carry / borrow status |
| st_n | output | 1 | Negative status |
| st_z | output | 1 | Zero status |
| st_v | output | 1 | Overflow status |
| st_gt | output | 1 | Greater-than-zero status |

## Verification
Every issued operation, and every idle cycle, affects `result`, `wr_en` and the status bits at the very next rising edge, one register stage after the inputs. The driver changes inputs only on falling edges. For each cycle it pushes one expected entry, computed by a reference model written in the bench. The monitor pops that entry 1 ns after the next rising edge, so each comparison lands exactly one cycle after its stimulus and the queue never holds more than one entry.

// File: rtl/dsp_incdec_pkg.sv
package dsp_incdec_pkg;

    // Cycle classification driving the output register stage
    typedef enum logic [1:0] {
        KIND_IDLE      = 2'd0,
        KIND_FULL      = 2'd1,
        KIND_DATA_ONLY = 2'd2,
        KIND_SQUASH    = 2'd3
    } issue_kind_e;

    typedef struct packed {
        logic dc;
        logic n;
        logic z;
        logic v;
        logic gt;
    } status_t;

endpackage

// File: rtl/incdec_slice_fmt.sv
module incdec_slice_fmt #(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32,
    localparam int HALF_W  = WORD_W / 2,
    localparam int SLICE_W = GUARD_W + HALF_W,
    localparam int REG_W   = GUARD_W + WORD_W
) (
    input  logic [REG_W-1:0]   src,
    input  logic               src_has_guard,
    output logic [SLICE_W-1:0] slice
);
    logic [GUARD_W-1:0] guard_sel;
    logic [HALF_W-1:0]  upper_half;
    logic               unused_low_half;

    assign upper_half      = src[WORD_W-1 -: HALF_W];
    assign unused_low_half = ^src[HALF_W-1:0];

    always_comb begin
        if (src_has_guard) begin
            guard_sel = src[REG_W-1 -: GUARD_W];
        end else begin
            guard_sel = {GUARD_W{src[WORD_W-1]}};
        end
    end

    assign slice = {guard_sel, upper_half};
endmodule

// File: rtl/incdec_step.sv
module incdec_step #(
    parameter int GUARD_W = 8,
    parameter int HALF_W  = 16,
    localparam int SLICE_W = GUARD_W + HALF_W
) (
    input  logic [SLICE_W-1:0] slice_in,
    input  logic               op_dec,
    input  logic               dst_has_guard,
    input  logic               sat_en,
    output logic [SLICE_W-1:0] slice_out,
    output logic               carry_flag,
    output logic               ovf_flag
);
    localparam logic [SLICE_W-1:0] SAT_POS = {{(GUARD_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [SLICE_W-1:0] SAT_NEG = {{(GUARD_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
    localparam logic [SLICE_W-1:0] FULL_MAX = {1'b0, {(SLICE_W-1){1'b1}}};
    localparam logic [SLICE_W-1:0] FULL_MIN = {1'b1, {(SLICE_W-1){1'b0}}};
    localparam logic [HALF_W-1:0]  HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0]  HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};

    logic [SLICE_W:0]   widened;
    logic [SLICE_W:0]   stepped;
    logic               ovf_full;
    logic               ovf_half;
    logic [HALF_W-1:0]  half_in;

    assign widened = {1'b0, slice_in};
    assign half_in = slice_in[HALF_W-1:0];

    always_comb begin
        if (op_dec) begin
            stepped  = widened - {{SLICE_W{1'b0}}, 1'b1};
            ovf_full = (slice_in == FULL_MIN);
            ovf_half = (half_in == HALF_MIN);
        end else begin
            stepped  = widened + {{SLICE_W{1'b0}}, 1'b1};
            ovf_full = (slice_in == FULL_MAX);
            ovf_half = (half_in == HALF_MAX);
        end
    end

    assign carry_flag = stepped[SLICE_W];
    assign ovf_flag   = dst_has_guard ? ovf_full : ovf_half;

    always_comb begin
        if (sat_en && ovf_flag) begin
            slice_out = op_dec ? SAT_NEG : SAT_POS;
        end else begin
            slice_out = stepped[SLICE_W-1:0];
        end
    end
endmodule

// File: rtl/incdec_pack.sv
module incdec_pack #(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32,
    localparam int HALF_W  = WORD_W / 2,
    localparam int SLICE_W = GUARD_W + HALF_W,
    localparam int REG_W   = GUARD_W + WORD_W
) (
    input  logic [SLICE_W-1:0] slice,
    input  logic               dst_has_guard,
    output logic [REG_W-1:0]   packed_val,
    output logic               neg_flag,
    output logic               zero_flag,
    output logic               gt_flag
);
    logic [GUARD_W-1:0] guard_out;

    always_comb begin
        if (dst_has_guard) begin
            guard_out = slice[SLICE_W-1 -: GUARD_W];
        end else begin
            guard_out = {GUARD_W{slice[HALF_W-1]}};
        end
    end

    assign packed_val = {guard_out, slice[HALF_W-1:0], {HALF_W{1'b0}}};
    assign neg_flag   = packed_val[REG_W-1];
    assign zero_flag  = ~|packed_val;
    assign gt_flag    = ~neg_flag & ~zero_flag;
endmodule

// File: rtl/dsp_incdec_alu.sv
module dsp_incdec_alu
    import dsp_incdec_pkg::*;
#(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32,
    localparam int HALF_W  = WORD_W / 2,
    localparam int SLICE_W = GUARD_W + HALF_W,
    localparam int REG_W   = GUARD_W + WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             op_dec,
    input  logic [REG_W-1:0] src_operand,
    input  logic             src_has_guard,
    input  logic             dst_has_guard,
    input  logic             sat_en,
    input  logic             cond_mode,
    input  logic             cond_true,
    output logic [REG_W-1:0] result,
    output logic             wr_en,
    output logic             st_dc,
    output logic             st_n,
    output logic             st_z,
    output logic             st_v,
    output logic             st_gt
);
    logic [SLICE_W-1:0] slice_src;
    logic [SLICE_W-1:0] slice_res;
    logic               carry_c;
    logic               ovf_c;
    logic [REG_W-1:0]   packed_c;
    logic               neg_c;
    logic               zero_c;
    logic               gt_c;

    issue_kind_e kind;
    status_t     status_q;
    status_t     status_c;
    logic        take_result;
    logic        take_status;
    logic [REG_W-1:0] result_q;
    logic             wr_en_q;

    incdec_slice_fmt #(.GUARD_W(GUARD_W), .WORD_W(WORD_W)) i_fmt (
        .src           (src_operand),
        .src_has_guard (src_has_guard),
        .slice         (slice_src)
    );

    incdec_step #(.GUARD_W(GUARD_W), .HALF_W(HALF_W)) i_step (
        .slice_in      (slice_src),
        .op_dec        (op_dec),
        .dst_has_guard (dst_has_guard),
        .sat_en        (sat_en),
        .slice_out     (slice_res),
        .carry_flag    (carry_c),
        .ovf_flag      (ovf_c)
    );

    incdec_pack #(.GUARD_W(GUARD_W), .WORD_W(WORD_W)) i_pack (
        .slice         (slice_res),
        .dst_has_guard (dst_has_guard),
        .packed_val    (packed_c),
        .neg_flag      (neg_c),
        .zero_flag     (zero_c),
        .gt_flag       (gt_c)
    );

    // Classify the current cycle
    always_comb begin
        if (!issue) begin
            kind = KIND_IDLE;
        end else if (!cond_mode) begin
            kind = KIND_FULL;
        end else if (cond_true) begin
            kind = KIND_DATA_ONLY;
        end else begin
            kind = KIND_SQUASH;
        end
    end

    // Effects of each kind on the output stage
    always_comb begin
        unique case (kind)
            KIND_IDLE: begin
                take_result = 1'b0;
                take_status = 1'b0;
            end
            KIND_FULL: begin
                take_result = 1'b1;
                take_status = 1'b1;
            end
            KIND_DATA_ONLY: begin
                take_result = 1'b1;
                take_status = 1'b0;
            end
            KIND_SQUASH: begin
                take_result = 1'b0;
                take_status = 1'b0;
            end
            default: begin
                take_result = 1'b0;
                take_status = 1'b0;
            end
        endcase
    end

    assign status_c = '{dc: carry_c, n: neg_c, z: zero_c, v: ovf_c, gt: gt_c};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            wr_en_q  <= 1'b0;
            status_q <= '0;
        end else begin
            wr_en_q <= take_result;
            if (take_result) begin
                result_q <= packed_c;
            end
            if (take_status) begin
                status_q <= status_c;
            end
        end
    end

    assign result = result_q;
    assign wr_en  = wr_en_q;
    assign st_dc  = status_q.dc;
    assign st_n   = status_q.n;
    assign st_z   = status_q.z;
    assign st_v   = status_q.v;
    assign st_gt  = status_q.gt;
endmodule

// File: rtl/incdec_alu_checks.sv
module incdec_alu_checks #(
    parameter int REG_W  = 40,
    parameter int WORD_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic             op_dec,
    input logic [REG_W-1:0] src_operand,
    input logic             src_has_guard,
    input logic             dst_has_guard,
    input logic             sat_en,
    input logic             cond_mode,
    input logic             cond_true,
    input logic [REG_W-1:0] result,
    input logic             wr_en,
    input logic             st_dc,
    input logic             st_n,
    input logic             st_z,
    input logic             st_v,
    input logic             st_gt
);
    localparam int HALF_W  = WORD_W / 2;
    localparam int GUARD_W = REG_W - WORD_W;

    logic [4:0] st_vec;
    assign st_vec = {st_dc, st_n, st_z, st_v, st_gt};

    a_r1_low_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (result[HALF_W-1:0] == '0));

    a_r4_guard_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !dst_has_guard && !(cond_mode && !cond_true)) |=>
            (result[REG_W-1 -: GUARD_W] == {GUARD_W{result[WORD_W-1]}}));

    a_r6_sat_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && sat_en && !cond_mode) |=>
            (st_v |-> (result[WORD_W-1 -: HALF_W] == {1'b0, {(HALF_W-1){1'b1}}}
                    || result[WORD_W-1 -: HALF_W] == {1'b1, {(HALF_W-1){1'b0}}})));

    a_r8_gt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        st_gt |-> (!st_n && !st_z));

    a_r8_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !cond_mode) |=> (st_n == result[REG_W-1]) && (st_z == (result == '0)));

    a_r10_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cond_mode) |=> $stable(st_vec));

    a_r10_cond_write: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cond_mode && cond_true) |=> wr_en);

    a_r11_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cond_mode && !cond_true) |=> (!wr_en && $stable(result)));

    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!wr_en && $stable(st_vec) && $stable(result)));
endmodule

bind dsp_incdec_alu incdec_alu_checks #(.REG_W(REG_W), .WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_dsp_incdec_alu.sv
`timescale 1ns/1ps
module test_dsp_incdec_alu;
    localparam int REG_W = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue = 1'b0;
    logic             op_dec = 1'b0;
    logic [REG_W-1:0] src_operand = '0;
    logic             src_has_guard = 1'b0;
    logic             dst_has_guard = 1'b0;
    logic             sat_en = 1'b0;
    logic             cond_mode = 1'b0;
    logic             cond_true = 1'b0;
    logic [REG_W-1:0] result;
    logic             wr_en;
    logic             st_dc, st_n, st_z, st_v, st_gt;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [REG_W-1:0] res_q[$];
    logic             we_q[$];
    logic [4:0]       st_q[$];
    string            tag_q[$];

    logic [REG_W-1:0] exp_res = '0;
    logic [4:0]       exp_st  = '0;

    always #2 clk = ~clk;

    dsp_incdec_alu i_dsp_incdec_alu (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_dec(op_dec),
        .src_operand(src_operand), .src_has_guard(src_has_guard),
        .dst_has_guard(dst_has_guard), .sat_en(sat_en),
        .cond_mode(cond_mode), .cond_true(cond_true),
        .result(result), .wr_en(wr_en),
        .st_dc(st_dc), .st_n(st_n), .st_z(st_z), .st_v(st_v), .st_gt(st_gt)
    );

    // Behavioural reference derived from the requirements
    task automatic ref_model(input logic dec, input logic [39:0] src, input logic sg,
                             input logic dg, input logic sat,
                             output logic [39:0] r, output logic [4:0] st);
        logic [7:0]  g;
        logic [15:0] top;
        logic [23:0] sl;
        int          s24, s16, w24, w16, d;
        logic        dc, v, n, z;
        g   = sg ? src[39:32] : {8{src[31]}};
        top = src[31:16];
        sl  = {g, top};
        d   = dec ? -1 : 1;
        s24 = int'($signed(sl));
        s16 = int'($signed(top));
        w24 = s24 + d;
        w16 = s16 + d;
        dc  = dec ? (sl == 24'h000000) : (sl == 24'hFFFFFF);
        if (dg) v = (w24 > 8388607) || (w24 < -8388608);
        else    v = (w16 > 32767) || (w16 < -32768);
        sl = sl + (dec ? 24'hFFFFFF : 24'h000001);
        if (sat && v) sl = dec ? 24'hFF8000 : 24'h007FFF;
        if (dg) r = {sl, 16'h0000};
        else    r = {{8{sl[15]}}, sl[15:0], 16'h0000};
        n  = r[39];
        z  = (r == 40'h0);
        st = {dc, n, z, v, ~n & ~z};
    endtask

    task automatic drive(input logic iss, input logic dec, input logic [39:0] src,
                         input logic sg, input logic dg, input logic sat,
                         input logic cm, input logic ct, input string tag);
        logic [39:0] r;
        logic [4:0]  st;
        logic        we;
        @(negedge clk);
        issue = iss; op_dec = dec; src_operand = src;
        src_has_guard = sg; dst_has_guard = dg; sat_en = sat;
        cond_mode = cm; cond_true = ct;
        ref_model(dec, src, sg, dg, sat, r, st);
        we = iss && (!cm || ct);
        if (we) exp_res = r;
        if (iss && !cm) exp_st = st;
        res_q.push_back(exp_res);
        we_q.push_back(we);
        st_q.push_back(exp_st);
        tag_q.push_back(tag);
    endtask

    // Monitor: one expected entry per cycle, due one edge after the stimulus
    always @(posedge clk) begin
        #1;
        if (res_q.size() > 0) begin
            logic [39:0] er;
            logic        ew;
            logic [4:0]  es;
            string       t;
            er = res_q.pop_front();
            ew = we_q.pop_front();
            es = st_q.pop_front();
            t  = tag_q.pop_front();
            n_vec++;
            if (result !== er || wr_en !== ew || {st_dc, st_n, st_z, st_v, st_gt} !== es) begin
                n_bad++;
                $display("FAIL %s: got res=%h we=%b st=%b, expected res=%h we=%b st=%b",
                         t, result, wr_en, {st_dc, st_n, st_z, st_v, st_gt}, er, ew, es);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got run still active, expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] tops [5];
        logic [7:0]  grds [4];
        tops = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000, 16'h1234};
        grds = '{8'h00, 8'h7F, 8'h80, 8'hFF};

        repeat (3) @(negedge clk);
        n_vec++;
        if (result !== 40'h0 || wr_en !== 1'b0 || {st_dc, st_n, st_z, st_v, st_gt} !== 5'b0) begin
            n_bad++;
            $display("FAIL R13: got res=%h we=%b st=%b, expected all zero",
                     result, wr_en, {st_dc, st_n, st_z, st_v, st_gt});
        end
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R13");

        // Directed corner cases
        drive(1'b1, 1'b0, 40'h00_7FFF_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        drive(1'b1, 1'b0, 40'h00_7FFF_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        drive(1'b1, 1'b0, 40'h00_7FFF_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        drive(1'b1, 1'b1, 40'h80_0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        drive(1'b1, 1'b0, 40'hFF_FFFF_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        drive(1'b1, 1'b1, 40'h00_0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        drive(1'b1, 1'b0, 40'h55_1234_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        drive(1'b1, 1'b1, 40'hAA_8001_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        drive(1'b1, 1'b0, 40'h12_1234_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        drive(1'b1, 1'b0, 40'h12_1234_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        drive(1'b1, 1'b1, 40'h3C_0001_A5A5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        drive(1'b1, 1'b0, 40'h00_FFFF_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        drive(1'b1, 1'b1, 40'h00_0005_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        drive(1'b1, 1'b1, 40'h00_0005_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R11");
        drive(1'b0, 1'b0, 40'hFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R12");
        drive(1'b1, 1'b1, 40'hFF_8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // Exhaustive sweep over modes, guard flags and corner top words
        for (int op = 0; op < 2; op++)
            for (int sg = 0; sg < 2; sg++)
                for (int dg = 0; dg < 2; dg++)
                    for (int sat = 0; sat < 2; sat++)
                        for (int cmode = 0; cmode < 3; cmode++)
                            for (int ti = 0; ti < 5; ti++)
                                for (int gi = 0; gi < 4; gi++) begin
                                    logic [39:0] s;
                                    string tg;
                                    s = {grds[gi], tops[ti], 16'(ti * 16'h3A11 + gi)};
                                    if (cmode == 2)      tg = "R11";
                                    else if (cmode == 1) tg = "R10";
                                    else if (sat != 0)   tg = "R6";
                                    else                 tg = "R5";
                                    drive(1'b1, op[0], s, sg[0], dg[0], sat[0],
                                          cmode != 0, cmode == 1, tg);
                                    if (gi == 3)
                                        drive(1'b0, op[0], s, sg[0], dg[0], sat[0],
                                              1'b0, 1'b0, "R12");
                                end

        drive(1'b0, 1'b0, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule